// File: doc/BRIEF.md
# Halfword-Select Multiply-Accumulate Unit

This block is a signed multiplier for 16-bit samples stored two per 32-bit word. A caller gives two 32-bit sources, a 32-bit addend, a two-bit operation code, two half-select bits and a one-cycle start strobe. It gets back a registered 32-bit result one cycle later. The narrow forms multiply one chosen half of each source. The wide forms multiply a whole 32-bit word by one chosen half of the second source and keep the upper 32 bits of the 48-bit product.

The accumulating forms add the product to the addend with plain 32-bit wraparound. When that addition leaves the signed 32-bit range, the unit pulses a request that the surrounding core uses to set its sticky overflow flag. The sum itself is never clamped. Operations that do not accumulate never raise the request.

Top module: `hmac_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `result` is zero and `valid` and `sat_set` are low.
- R2: `valid` is high in exactly the cycle after each cycle in which `start` is high. `result` keeps its value in every cycle that follows a cycle with `start` low.
- R3: In the 16x16 forms, `sel_a` picks the operand half of `src_a` and `sel_b` picks the operand half of `src_b`. Value 0 picks bits 15:0 and value 1 picks bits 31:16. Each half is taken as a signed two's-complement number.
- R4: `op` encoding: 2'b00 is a 16x16 multiply, 2'b01 is a 16x16 multiply plus `acc_in`, 2'b10 is a 32x16 multiply, and 2'b11 is a 32x16 multiply plus `acc_in`.
- R5: The 32x16 forms multiply all of `src_a` (signed) by the half of `src_b` chosen by `sel_b`, and return bits 47:16 of the signed 48-bit product. `sel_a` has no effect in these forms.
- R6: The accumulating forms return the product plus `acc_in`, modulo 2^32. The result is not saturated.
- R7: `sat_set` is high together with `valid` exactly when an accumulating operation's true sum lies outside -2^31 to 2^31-1.
- R8: A non-accumulating operation never raises `sat_set`, whatever the value of `acc_in`.
- R9: The 16x16 product of -32768 by -32768 is returned as 0x40000000 and does not raise `sat_set`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches one operation |
| op | input | 2 | Operation code |
| sel_a | input | 1 | Half select for `src_a` (16x16 forms only) |
| sel_b | input | 1 | Half select for `src_b` |
| src_a | input | 32 | First source word |
| src_b | input | 32 | Second source word |
| acc_in | input | 32 | Addend for the accumulating forms |
| result | output | 32 | Registered result |
| valid | output | 1 | Result updated this cycle |
| sat_set | output | 1 | Request to set the sticky overflow flag |

## Verification
The bench drives all four select combinations with halves of different sign and size. A design that swapped halves or zero-extended them returns a visibly wrong product. It pushes accumulations past both ends of the signed range, where a saturating adder would return the clamp value and a missing overflow detector would leave the request low. It also gives `acc_in` near the limits to plain multiplies, where a spurious request would show. Finally it checks the -32768 squared case and the 32x16 shift by sixteen: the first catches a design that flags overflow on the multiply, and the second catches one that keeps the low product bits or lets `sel_a` steer the wide forms.

// File: rtl/hmac_pkg.sv
package hmac_pkg;

    localparam int HALF_W = 16;
    localparam int WORD_W = 2 * HALF_W;
    localparam int PROD_W = WORD_W + HALF_W;

    typedef enum logic [1:0] {
        OP_MUL_HH = 2'b00,
        OP_MAC_HH = 2'b01,
        OP_MUL_WH = 2'b10,
        OP_MAC_WH = 2'b11
    } op_e;

    typedef struct packed {
        logic [WORD_W-1:0] value;
        logic              ovf;
    } res_t;

    function automatic logic [HALF_W-1:0] pick_half(input logic [WORD_W-1:0] w,
                                                    input logic upper);
        return upper ? w[WORD_W-1:HALF_W] : w[HALF_W-1:0];
    endfunction

    function automatic logic is_accum(input op_e o);
        return o[0];
    endfunction

    function automatic logic is_wide(input op_e o);
        return o[1];
    endfunction

endpackage

// File: rtl/hmac_opsel.sv
module hmac_opsel
    import hmac_pkg::*;
#(
    parameter int HW = HALF_W,
    parameter int WW = WORD_W
) (
    input  op_e           op,
    input  logic          sel_a,
    input  logic          sel_b,
    input  logic [WW-1:0] src_a,
    input  logic [WW-1:0] src_b,
    output logic [WW-1:0] mul_a,
    output logic [HW-1:0] mul_b,
    output logic          wide
);
    logic [HW-1:0] half_a;

    always_comb begin
        wide   = is_wide(op);
        half_a = sel_a ? src_a[WW-1:HW] : src_a[HW-1:0];
        mul_b  = sel_b ? src_b[WW-1:HW] : src_b[HW-1:0];
        if (wide) begin
            mul_a = src_a;
        end else begin
            mul_a = {{(WW-HW){half_a[HW-1]}}, half_a};
        end
    end
endmodule

// File: rtl/hmac_mult.sv
module hmac_mult
    import hmac_pkg::*;
#(
    parameter int HW = HALF_W,
    parameter int WW = WORD_W
) (
    input  logic [WW-1:0] mul_a,
    input  logic [HW-1:0] mul_b,
    input  logic          wide,
    output logic [WW-1:0] product
);
    localparam int PW = WW + HW;

    logic [PW-1:0] ext_a;
    logic [PW-1:0] ext_b;
    logic [PW-1:0] full;

    always_comb begin
        ext_a = {{HW{mul_a[WW-1]}}, mul_a};
        ext_b = {{WW{mul_b[HW-1]}}, mul_b};
        full  = ext_a * ext_b;
        if (wide) begin
            product = full[PW-1:HW];
        end else begin
            product = full[WW-1:0];
        end
    end
endmodule

// File: rtl/hmac_accum.sv
module hmac_accum
    import hmac_pkg::*;
#(
    parameter int WW = WORD_W
) (
    input  logic [WW-1:0] product,
    input  logic [WW-1:0] addend,
    input  logic          acc_en,
    output res_t          res
);
    logic [WW-1:0] sum;
    logic          same_sign;

    always_comb begin
        sum       = product + addend;
        same_sign = (product[WW-1] == addend[WW-1]);
        if (acc_en) begin
            res.value = sum;
            res.ovf   = same_sign && (sum[WW-1] != product[WW-1]);
        end else begin
            res.value = product;
            res.ovf   = 1'b0;
        end
    end
endmodule

// File: rtl/hmac_unit.sv
module hmac_unit
    import hmac_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [1:0]  op,
    input  logic        sel_a,
    input  logic        sel_b,
    input  logic [31:0] src_a,
    input  logic [31:0] src_b,
    input  logic [31:0] acc_in,
    output logic [31:0] result,
    output logic        valid,
    output logic        sat_set
);
    op_e           op_q;
    logic [WORD_W-1:0] mul_a;
    logic [HALF_W-1:0] mul_b;
    logic          wide;
    logic [WORD_W-1:0] product;
    res_t          res;

    assign op_q = op_e'(op);

    hmac_opsel #(.HW(HALF_W), .WW(WORD_W)) u_opsel (
        .op    (op_q),
        .sel_a (sel_a),
        .sel_b (sel_b),
        .src_a (src_a),
        .src_b (src_b),
        .mul_a (mul_a),
        .mul_b (mul_b),
        .wide  (wide)
    );

    hmac_mult #(.HW(HALF_W), .WW(WORD_W)) u_mult (
        .mul_a   (mul_a),
        .mul_b   (mul_b),
        .wide    (wide),
        .product (product)
    );

    hmac_accum #(.WW(WORD_W)) u_accum (
        .product (product),
        .addend  (acc_in),
        .acc_en  (is_accum(op_q)),
        .res     (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result  <= '0;
            valid   <= 1'b0;
            sat_set <= 1'b0;
        end else begin
            valid   <= start;
            sat_set <= start && res.ovf;
            if (start) begin
                result <= res.value;
            end
        end
    end
endmodule

// File: rtl/hmac_unit_chk.sv
module hmac_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic [1:0]  op,
    input logic [31:0] acc_in,
    input logic [31:0] result,
    input logic        valid,
    input logic        sat_set
);
    // R2
    valid_follows_start_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> valid);

    // R2
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> !valid);

    // R2
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(result));

    // R7
    sat_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        sat_set |-> valid);

    // R8
    no_sat_on_mul_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !op[0]) |=> !sat_set);

    // R7
    wrap_sign_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (start && op[0]) |=> (!sat_set || (result[31] != $past(acc_in[31]))));
endmodule

bind hmac_unit hmac_unit_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .op      (op),
    .acc_in  (acc_in),
    .result  (result),
    .valid   (valid),
    .sat_set (sat_set)
);

// File: tb/tb_hmac_unit.sv
`timescale 1ns/1ps
module tb_hmac_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [1:0]  op;
    logic        sel_a, sel_b;
    logic [31:0] src_a, src_b, acc_in;
    logic [31:0] result;
    logic        valid, sat_set;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    hmac_unit dut (
        .clk(clk), .rst(rst), .start(start), .op(op), .sel_a(sel_a), .sel_b(sel_b),
        .src_a(src_a), .src_b(src_b), .acc_in(acc_in),
        .result(result), .valid(valid), .sat_set(sat_set)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic longint half_val(input logic [31:0] w, input logic up);
        logic signed [15:0] h;
        h = up ? w[31:16] : w[15:0];
        return longint'(h);
    endfunction

    function automatic void model(input logic [1:0] o, input logic sa, input logic sb,
                                  input logic [31:0] a, input logic [31:0] b,
                                  input logic [31:0] c, output logic [31:0] r,
                                  output logic f);
        longint p, s;
        logic [63:0] pv;
        if (o[1]) begin
            p  = longint'($signed(a)) * half_val(b, sb);
            pv = p;
            p  = longint'($signed(pv[47:16]));
        end else begin
            p = half_val(a, sa) * half_val(b, sb);
        end
        if (o[0]) begin
            s = p + longint'($signed(c));
            f = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        end else begin
            s = p;
            f = 1'b0;
        end
        pv = s;
        r  = pv[31:0];
    endfunction

    task automatic run_op(input string req, input logic [1:0] o, input logic sa,
                          input logic sb, input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] c);
        logic [31:0] er;
        logic        ef;
        model(o, sa, sb, a, b, c, er, ef);
        @(negedge clk);
        start = 1'b1; op = o; sel_a = sa; sel_b = sb; src_a = a; src_b = b; acc_in = c;
        @(negedge clk);
        start = 1'b0;
        check({req, " valid"}, {31'b0, valid}, 32'd1);
        check({req, " result"}, result, er);
        check({req, " sat_set"}, {31'b0, sat_set}, {31'b0, ef});
    endtask

    task automatic t_reset;
        rst = 1'b1; start = 1'b0; op = 2'b00; sel_a = 0; sel_b = 0;
        src_a = '0; src_b = '0; acc_in = '0;
        repeat (3) @(negedge clk);
        check("R1 result in reset", result, 32'd0);
        check("R1 valid in reset", {31'b0, valid}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after reset", {31'b0, valid}, 32'd0);
        check("R1 sat_set after reset", {31'b0, sat_set}, 32'd0);
    endtask

    task automatic t_half_select;
        for (int i = 0; i < 4; i++) begin
            run_op("R3 half select", 2'b00, i[0], i[1], 32'h0003_FFFE, 32'hFFF9_0005, 32'h0);
        end
        run_op("R3 sel_a=1 sel_b=0 exact", 2'b00, 1'b1, 1'b0, 32'h0003_FFFE, 32'hFFF9_0005, 32'h0);
        check("R3 3*5", result, 32'd15);
    endtask

    task automatic t_mac16;
        run_op("R4 mac16 plain", 2'b01, 1'b0, 1'b1, 32'h0000_0064, 32'h0007_0000, 32'd1000);
        check("R6 100*7+1000", result, 32'd1700);
        run_op("R6 R7 positive wrap", 2'b01, 1'b0, 1'b0, 32'h0000_0100, 32'h0000_0100, 32'h7FFF_FFF0);
        check("R6 wrapped value", result, 32'h8000_FFF0);
        check("R7 positive overflow", {31'b0, sat_set}, 32'd1);
        run_op("R6 R7 negative wrap", 2'b01, 1'b0, 1'b0, 32'h0000_FFFF, 32'h0000_0002, 32'h8000_0000);
        check("R6 negative wrapped", result, 32'h7FFF_FFFE);
        run_op("R7 sum at max no flag", 2'b01, 1'b0, 1'b0, 32'h0000_0001, 32'h0000_0001, 32'h7FFF_FFFE);
        check("R7 no overflow at limit", {31'b0, sat_set}, 32'd0);
    endtask

    task automatic t_extreme;
        run_op("R9 min squared", 2'b00, 1'b1, 1'b0, 32'h8000_1234, 32'h5555_8000, 32'h0);
        check("R9 value", result, 32'h4000_0000);
        run_op("R9 R7 min squared plus", 2'b01, 1'b1, 1'b0, 32'h8000_1234, 32'h5555_8000, 32'h4000_0000);
        check("R7 flag on 2^31", {31'b0, sat_set}, 32'd1);
    endtask

    task automatic t_wide;
        logic [31:0] first;
        run_op("R5 wide lower", 2'b10, 1'b0, 1'b0, 32'h1234_5678, 32'hAAAA_0002, 32'h0);
        check("R5 bits 47:16", result, 32'h0000_2468);
        first = result;
        run_op("R5 sel_a ignored", 2'b10, 1'b1, 1'b0, 32'h1234_5678, 32'hAAAA_0002, 32'h0);
        check("R5 sel_a no effect", result, first);
        run_op("R5 wide upper negative", 2'b10, 1'b0, 1'b1, 32'h0001_0000, 32'hFFFD_0007, 32'h0);
        check("R5 -3 * 65536 >> 16", result, 32'hFFFF_FFFD);
        run_op("R5 wide min", 2'b10, 1'b0, 1'b0, 32'h8000_0000, 32'h0000_8000, 32'h0);
        run_op("R4 mac wide", 2'b11, 1'b0, 1'b1, 32'h7FFF_FFFF, 32'h7FFF_0000, 32'h7000_0000);
        run_op("R4 mac wide small", 2'b11, 1'b1, 1'b0, 32'h0003_0000, 32'h0000_0004, 32'd5);
        check("R4 3*4+5", result, 32'd17);
    endtask

    task automatic t_no_sat_mul;
        run_op("R8 mul16 big acc", 2'b00, 1'b0, 1'b0, 32'h0000_7FFF, 32'h0000_7FFF, 32'h7FFF_FFFF);
        check("R8 no flag mul16", {31'b0, sat_set}, 32'd0);
        run_op("R8 mul wide big acc", 2'b10, 1'b0, 1'b1, 32'h7FFF_FFFF, 32'h7FFF_0000, 32'h8000_0000);
        check("R8 no flag wide", {31'b0, sat_set}, 32'd0);
    endtask

    task automatic t_hold;
        logic [31:0] keep;
        logic [31:0] er1, er2;
        logic        f1, f2;
        run_op("R2 base", 2'b00, 1'b0, 1'b0, 32'h0000_0009, 32'h0000_0009, 32'h0);
        keep = result;
        @(negedge clk);
        check("R2 valid drops", {31'b0, valid}, 32'd0);
        src_a = 32'hFFFF_FFFF; src_b = 32'h1234_5678; op = 2'b01; acc_in = 32'h7FFF_FFFF;
        repeat (2) @(negedge clk);
        check("R2 result held", result, keep);
        check("R2 no flag idle", {31'b0, sat_set}, 32'd0);
        model(2'b00, 1'b0, 1'b0, 32'h0000_0002, 32'h0000_0003, 32'h0, er1, f1);
        model(2'b01, 1'b0, 1'b0, 32'h0000_0004, 32'h0000_0005, 32'd1, er2, f2);
        start = 1'b1; op = 2'b00; sel_a = 0; sel_b = 0;
        src_a = 32'd2; src_b = 32'd3; acc_in = 32'd0;
        @(negedge clk);
        op = 2'b01; src_a = 32'd4; src_b = 32'd5; acc_in = 32'd1;
        check("R2 back-to-back first valid", {31'b0, valid}, 32'd1);
        check("R2 back-to-back first", result, er1);
        @(negedge clk);
        start = 1'b0;
        check("R2 back-to-back second valid", {31'b0, valid}, 32'd1);
        check("R2 back-to-back second", result, er2);
        @(negedge clk);
        check("R2 valid after burst", {31'b0, valid}, 32'd0);
    endtask

    initial begin
        t_reset();
        t_half_select();
        t_mac16();
        t_extreme();
        t_wide();
        t_no_sat_mul();
        t_hold();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule